// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which event a processor core services next. It takes four dedicated event classes and nine general-purpose interrupt levels. The dedicated classes are emulation, system reset, non-maskable and exception. The block selects the most urgent request that is pending and enabled. It takes that request only when it outranks every handler already running, so handlers nest. When it takes an event, it raises a one-cycle `take_o` pulse, presents the level number on `vec_o`, and marks the level in the active set. A return strobe ends the most urgent running handler. Arbitration then resumes after a one-cycle settle.

Levels are numbered 0 to 15, and a smaller number is more urgent:

| Level | Source |
|---|---|
| 0 | emulation |
| 1 | system reset |
| 2 | non-maskable |
| 3 | exception |
| 4 to 6 | unused, never pending |
| 7 to 13 | peripheral request lines, which software can also raise |
| 14 to 15 | software raise only |

A mask register enables the general-purpose levels. The dedicated levels ignore it.

A three-state machine sequences the controller:
- **IDLE**: no handler is running. A take moves it to NESTED.
- **NESTED**: one or more handlers are running. A return moves it to RETIRE.
- **RETIRE**: the settle cycle after a return. A further return stays in RETIRE. Otherwise it moves to NESTED if handlers remain, or to IDLE if none do.

Top module: `evc_ctrl`

## Requirements
- R1: After reset, `take_o` is 0, `vec_o` is 0, `active_o` is all zero, and every general-purpose level is masked, so raising one produces no take.
- R2: Among eligible pending levels, the one with the smallest number is taken.
- R3: Emulation (level 0), system reset (level 1), non-maskable (level 2) and exception (level 3) are taken regardless of the mask. The non-maskable level is set by either `wdog_nmi_i` or `pin_nmi_i`.
- R4: Bit k of `irq_i` requests level 7+k (k = 0..6). Bit k of `sw_raise_i` requests level 7+k (k = 0..8). Bit k of the mask (written with `mask_wdata_i` when `mask_we_i` is 1) enables level 7+k when it is 1.
- R5: A pending level stays pending until taken. A request that arrives while its level is masked is taken once the level is unmasked.
- R6: A request sampled at clock edge k is reflected in `take_o`=1 and `vec_o` during the cycle after edge k+1. `take_o` is high for one cycle per take, and the taken level's bit is set in `active_o`.
- R7: A pending level is taken only if its number is smaller than that of every active level. Less urgent requests wait while a handler runs.
- R8: `ret_i` clears the lowest-numbered bit of `active_o`. No take occurs at the edge that samples `ret_i`, nor at the following edge. After that, arbitration resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| emu_req_i | input | 1 | emulation event request (level 0) |
| sysrst_req_i | input | 1 | system reset event request (level 1) |
| wdog_nmi_i | input | 1 | non-maskable request from the watchdog (level 2) |
| pin_nmi_i | input | 1 | non-maskable request from the external pin (level 2) |
| exc_req_i | input | 1 | synchronous exception request (level 3) |
| irq_i | input | 7 | peripheral requests for levels 7..13 |
| sw_raise_i | input | 9 | software raise, one bit per level 7..15 |
| mask_we_i | input | 1 | mask register write enable |
| mask_wdata_i | input | 9 | mask write data, 1 = level enabled |
| ret_i | input | 1 | return-from-event strobe |
| take_o | output | 1 | one-cycle pulse: an event was taken |
| vec_o | output | 4 | level number of the last taken event |
| active_o | output | 16 | set of levels whose handlers are running |

## Verification
A request is registered into the pending set at one edge and arbitrated at the next. The bench therefore drives each request for one cycle at a falling edge and reads `take_o` and `vec_o` at the falling edge two rising edges later. It also confirms that `take_o` is still low one edge earlier and low again one edge later. A return updates `active_o` at the edge that samples it. The bench checks that `take_o` stays low at that edge and at the next one, and that a take follows only at the third edge. A mask write takes effect one edge before the arbitration that uses it, so unmask tests allow two edges before reading the take.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NESTED,
        ST_RETIRE
    } evc_state_e;

    localparam int unsigned EVC_LVL_EMU  = 0;
    localparam int unsigned EVC_LVL_RST  = 1;
    localparam int unsigned EVC_LVL_NMI  = 2;
    localparam int unsigned EVC_LVL_EXC  = 3;
    localparam int unsigned EVC_NUM_DED  = 4;

endpackage

// File: rtl/evc_prio_enc.sv
module evc_prio_enc #(
    parameter int unsigned W  = 16,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
        vld_o = |req_i;
    end

endmodule

// File: rtl/evc_pending.sv
module evc_pending #(
    parameter int unsigned NUM_LVL = 16,
    parameter int unsigned GP_BASE = 7,
    localparam int unsigned NUM_GP = NUM_LVL - GP_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] set_i,
    input  logic [NUM_LVL-1:0] clr_i,
    input  logic               mask_we_i,
    input  logic [NUM_GP-1:0]  mask_wdata_i,
    output logic [NUM_LVL-1:0] elig_o
);
    import evc_pkg::*;

    logic [NUM_LVL-1:0] pend_q;
    logic [NUM_GP-1:0]  mask_q;
    logic [NUM_LVL-1:0] en;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_en
        if (g < EVC_NUM_DED) begin : g_ded
            assign en[g] = 1'b1;
        end else if (g < GP_BASE) begin : g_gap
            assign en[g] = 1'b0;
        end else begin : g_gp
            assign en[g] = mask_q[g-GP_BASE];

            // R4: a general-purpose level is only taken while enabled
            a_r4_mask_gates_take: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[g] |-> mask_q[g-GP_BASE]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | (set_i & en | set_i & ~en);
            if (mask_we_i) mask_q <= mask_wdata_i;
        end
    end

    assign elig_o = pend_q & en;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_chk
        // R5: pending holds until the level is taken
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
    end

endmodule

// File: rtl/evc_active.sv
module evc_active #(
    parameter int unsigned NUM_LVL = 16,
    localparam int unsigned VW = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] set_i,
    input  logic               ret_i,
    output logic [NUM_LVL-1:0] act_o,
    output logic               top_vld_o,
    output logic [VW-1:0]      top_idx_o
);

    logic [NUM_LVL-1:0] act_q;
    logic [NUM_LVL-1:0] clr_oh;

    evc_prio_enc #(.W(NUM_LVL)) u_top (
        .req_i (act_q),
        .vld_o (top_vld_o),
        .idx_o (top_idx_o)
    );

    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) begin
            clr_oh[i] = ret_i && top_vld_o && (int'(top_idx_o) == i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= (act_q & ~clr_oh) | set_i;
    end

    assign act_o = act_q;

    // R8: a return removes exactly one running level
    a_r8_ret_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && top_vld_o) |=> ($countones(act_q) + 1 == $past($countones(act_q))));

endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl #(
    parameter int unsigned NUM_LVL    = 16,
    parameter int unsigned GP_BASE    = 7,
    parameter int unsigned NUM_PERIPH = 7,
    localparam int unsigned NUM_GP    = NUM_LVL - GP_BASE,
    localparam int unsigned VW        = $clog2(NUM_LVL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  emu_req_i,
    input  logic                  sysrst_req_i,
    input  logic                  wdog_nmi_i,
    input  logic                  pin_nmi_i,
    input  logic                  exc_req_i,
    input  logic [NUM_PERIPH-1:0] irq_i,
    input  logic [NUM_GP-1:0]     sw_raise_i,
    input  logic                  mask_we_i,
    input  logic [NUM_GP-1:0]     mask_wdata_i,
    input  logic                  ret_i,
    output logic                  take_o,
    output logic [VW-1:0]         vec_o,
    output logic [NUM_LVL-1:0]    active_o
);
    import evc_pkg::*;

    evc_state_e         state_q, state_d;
    logic [NUM_LVL-1:0] set_vec, elig, take_oh, le_vec;
    logic               win_vld, act_vld, take_ok;
    logic [VW-1:0]      win_idx, act_idx;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_set
        if (g == EVC_LVL_EMU) begin : g_emu
            assign set_vec[g] = emu_req_i;
        end else if (g == EVC_LVL_RST) begin : g_rst
            assign set_vec[g] = sysrst_req_i;
        end else if (g == EVC_LVL_NMI) begin : g_nmi
            assign set_vec[g] = wdog_nmi_i | pin_nmi_i;
        end else if (g == EVC_LVL_EXC) begin : g_exc
            assign set_vec[g] = exc_req_i;
        end else if (g < GP_BASE) begin : g_gap
            assign set_vec[g] = 1'b0;
        end else if (g - GP_BASE < NUM_PERIPH) begin : g_per
            assign set_vec[g] = sw_raise_i[g-GP_BASE] | irq_i[g-GP_BASE];
        end else begin : g_sw
            assign set_vec[g] = sw_raise_i[g-GP_BASE];
        end
    end

    evc_pending #(.NUM_LVL(NUM_LVL), .GP_BASE(GP_BASE)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_vec),
        .clr_i        (take_oh),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .elig_o       (elig)
    );

    evc_prio_enc #(.W(NUM_LVL)) u_win (
        .req_i (elig),
        .vld_o (win_vld),
        .idx_o (win_idx)
    );

    evc_active #(.NUM_LVL(NUM_LVL)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take_oh),
        .ret_i     (ret_i),
        .act_o     (active_o),
        .top_vld_o (act_vld),
        .top_idx_o (act_idx)
    );

    // next state and take decision
    always_comb begin
        state_d = state_q;
        take_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take_ok = !ret_i && win_vld;
                if (take_ok) state_d = ST_NESTED;
            end
            ST_NESTED: begin
                take_ok = !ret_i && win_vld && (!act_vld || win_idx < act_idx);
                if (ret_i) state_d = ST_RETIRE;
            end
            ST_RETIRE: begin
                if (ret_i && act_vld) state_d = ST_RETIRE;
                else if (act_vld && !ret_i) state_d = ST_NESTED;
                else state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) begin
            take_oh[i] = take_ok && (int'(win_idx) == i);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            vec_o  <= '0;
        end else begin
            take_o <= take_ok;
            if (take_ok) vec_o <= win_idx;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) begin
            le_vec[i] = (i <= int'(vec_o));
        end
    end

    // R7: a take only happens above every previously running level
    a_r7_outranks_active: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(active_o) & le_vec) == '0));

    // R6: the taken level is marked running
    a_r6_take_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> active_o[vec_o]);

    // R8: no take at the edge that samples a return
    a_r8_ret_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> !take_o);

    // R7: the idle state means nothing is running
    a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (active_o == '0));

endmodule

// File: tb/tb_evc_ctrl.sv
module tb_evc_ctrl;

    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_req_i = 1'b0, sysrst_req_i = 1'b0, wdog_nmi_i = 1'b0;
    logic        pin_nmi_i = 1'b0, exc_req_i = 1'b0;
    logic [6:0]  irq_i = '0;
    logic [8:0]  sw_raise_i = '0;
    logic        mask_we_i = 1'b0;
    logic [8:0]  mask_wdata_i = '0;
    logic        ret_i = 1'b0;
    logic        take_o;
    logic [3:0]  vec_o;
    logic [15:0] active_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(TCLK/2) clk = ~clk;

    evc_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .emu_req_i(emu_req_i), .sysrst_req_i(sysrst_req_i),
        .wdog_nmi_i(wdog_nmi_i), .pin_nmi_i(pin_nmi_i), .exc_req_i(exc_req_i),
        .irq_i(irq_i), .sw_raise_i(sw_raise_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .ret_i(ret_i), .take_o(take_o), .vec_o(vec_o), .active_o(active_o)
    );

    // {mask[33:25], irq[24:18], sw[17:9], ded{exc,nmi,rst,emu}[8:5], take[4], vec[3:0]}
    localparam int NV = 10;
    localparam logic [33:0] VECS [NV] = '{
        {9'h1FF, 7'h00, 9'h100, 4'b0000, 1'b1, 4'd15},
        {9'h1FF, 7'h40, 9'h100, 4'b0000, 1'b1, 4'd13},
        {9'h1FF, 7'h41, 9'h000, 4'b0000, 1'b1, 4'd7},
        {9'h1FE, 7'h41, 9'h000, 4'b0000, 1'b1, 4'd13},
        {9'h000, 7'h7F, 9'h1FF, 4'b0000, 1'b0, 4'd0},
        {9'h000, 7'h00, 9'h000, 4'b1000, 1'b1, 4'd3},
        {9'h1FF, 7'h01, 9'h000, 4'b0100, 1'b1, 4'd2},
        {9'h1FF, 7'h00, 9'h000, 4'b0011, 1'b1, 4'd0},
        {9'h000, 7'h00, 9'h000, 4'b0010, 1'b1, 4'd1},
        {9'h1FF, 7'h10, 9'h004, 4'b0000, 1'b1, 4'd9}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {emu_req_i, sysrst_req_i, wdog_nmi_i, pin_nmi_i, exc_req_i} = '0;
        irq_i = '0; sw_raise_i = '0; mask_we_i = 1'b0; ret_i = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic pulse_and_wait();
        cyc();
        {emu_req_i, sysrst_req_i, wdog_nmi_i, pin_nmi_i, exc_req_i} = '0;
        irq_i = '0; sw_raise_i = '0;
        cyc();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 take", 32'(take_o), 0);
        chk("R1 vec", 32'(vec_o), 0);
        chk("R1 active", 32'(active_o), 0);

        // table: priority and mapping from a clean start
        for (int e = 0; e < NV; e++) begin
            do_reset();
            mask_we_i = 1'b1; mask_wdata_i = VECS[e][33:25];
            cyc();
            mask_we_i = 1'b0;
            irq_i = VECS[e][24:18];
            sw_raise_i = VECS[e][17:9];
            {exc_req_i, wdog_nmi_i, sysrst_req_i, emu_req_i} = VECS[e][8:5];
            pulse_and_wait();
            chk("R2 R3 R4 take", 32'(take_o), 32'(VECS[e][4]));
            if (VECS[e][4]) chk("R2 R3 R4 vec", 32'(vec_o), 32'(VECS[e][3:0]));
        end

        // R1/R5: masked request is held, then taken after unmask
        do_reset();
        sw_raise_i = 9'h004;               // level 9
        pulse_and_wait();
        cyc();
        chk("R1 masked take", 32'(take_o), 0);
        chk("R1 masked active", 32'(active_o), 0);
        mask_we_i = 1'b1; mask_wdata_i = 9'h1FF;
        cyc();
        mask_we_i = 1'b0;
        chk("R6 not yet", 32'(take_o), 0);
        cyc();
        chk("R5 take", 32'(take_o), 1);
        chk("R5 vec", 32'(vec_o), 9);
        cyc();
        chk("R6 one-cycle pulse", 32'(take_o), 0);

        // R7 nesting: level 8 preempts 9
        irq_i = 7'h02;
        pulse_and_wait();
        chk("R7 preempt take", 32'(take_o), 1);
        chk("R7 preempt vec", 32'(vec_o), 8);
        chk("R6 R7 active", 32'(active_o), 32'h0300);
        // level 12 must wait behind 8
        sw_raise_i = 9'h020;
        pulse_and_wait();
        cyc();
        chk("R7 lower waits", 32'(take_o), 0);
        chk("R7 lower active", 32'(active_o), 32'h0300);
        // exception preempts running GP handlers
        exc_req_i = 1'b1;
        pulse_and_wait();
        chk("R3 exc take", 32'(take_o), 1);
        chk("R3 exc vec", 32'(vec_o), 3);
        chk("R7 three active", 32'(active_o), 32'h0308);

        // R8 returns
        ret_i = 1'b1;
        cyc();
        chk("R8 clear top", 32'(active_o), 32'h0300);
        chk("R8 no take on ret", 32'(take_o), 0);
        cyc();
        chk("R8 clear 8", 32'(active_o), 32'h0200);
        cyc();
        ret_i = 1'b0;
        chk("R8 clear 9", 32'(active_o), 32'h0000);
        chk("R8 no take", 32'(take_o), 0);
        cyc();
        chk("R8 settle no take", 32'(take_o), 0);
        cyc();
        chk("R8 resume take", 32'(take_o), 1);
        chk("R8 resume vec", 32'(vec_o), 12);

        // R3 pin NMI ignores mask, then emulation preempts it
        do_reset();
        pin_nmi_i = 1'b1;
        pulse_and_wait();
        chk("R3 pin nmi vec", {28'(take_o), vec_o}, {28'd1, 4'd2});
        emu_req_i = 1'b1;
        pulse_and_wait();
        chk("R3 emu vec", {28'(take_o), vec_o}, {28'd1, 4'd0});
        chk("R7 emu active", 32'(active_o), 32'h0005);
        ret_i = 1'b1;
        cyc();
        ret_i = 1'b0;
        chk("R8 emu retired", 32'(active_o), 32'h0004);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule